// File: doc/BRIEF.md
# Carry-Save Array Multiplier

An unsigned multiplier that takes two N-bit operands and returns their full 2N-bit product. It is built as a regular two-dimensional array. Every partial-product bit is a two-input AND of one bit from each operand. Each further multiplier bit adds one row of full-adder cells to the array. A cell's carry goes down to the cell beneath it in the next row instead of along its own row, so the array never forms a long horizontal carry chain.

The least significant cell of each row produces one finished low-order product bit. The first of these bits is the bare AND of the two operand LSBs. After the last row, a sum vector and a carry vector are still unmerged. A carry-select adder below the array combines them into the upper half of the product. That adder works in 4-bit blocks, and each block computes its result for both carry-in values ahead of time. An optional output register gives the block one cycle of latency. Without it, the block is purely combinational.

Top module: `csa_mult`

## Requirements
- R1: `p` equals the unsigned product of `a` and `b`, zero-extended to 2N bits, for every pair of operand values.
- R2: With `REG_OUT`=1, `p` shows the product of the operands present at the previous rising edge of `clk`. With `REG_OUT`=0, `p` follows the operands with no clock involved.
- R3: While `rst_n` is low, the registered `p` is 0 whatever the operands are. The reset is asynchronous and active low.
- R4: Bit 0 of `p` equals `a[0] & b[0]`.
- R5: For all-ones operands, `p` equals (2^N-1)^2, which is 0xFE01 for N=8. The final merge never produces a carry above bit 2N-1, including when a carry crosses every 4-bit block of that adder.
- R6: When either operand is zero, `p` is zero.
- R7: When one operand is 1, `p` equals the other operand, zero-extended.
- R8: When `b` is 2^k, `p` equals `a` shifted left by k bits, for every k from 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| p | output | 2N | Product, unsigned |

## Verification
At N=4 the combinational variant is tried on every operand pair. An error in any cell, or in any carry path down the array, therefore shows up somewhere in the results. At N=8 the registered variant runs random pairs, then several directed sets:
- Zero and unit operands, which separate the AND plane from the adders.
- A single-bit multiplier walked through every row, which makes each row's contribution visible on its own.
- All-ones and near-all-ones operands, which push carries through every block of the carry-select merge and expose a wrong block-select choice.

A reset applied while operands are driven shows whether the output register clears as it should.

// File: rtl/csa_mult.sv
module csa_mult #(
  parameter int N       = 8,
  parameter int REG_OUT = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int BLK = 4;
  localparam int NB  = (N + BLK - 1) / BLK;
  localparam int W   = NB * BLK;

  logic [N-1:0]   s [N];
  logic [N-1:0]   c [N];
  logic [N-1:0]   lo;
  logic [W-1:0]   fa, fb, fs;
  logic [NB:0]    bc;
  logic [2*N-1:0] prod;
  logic           merge_ovf;

  assign s[0] = a & {N{b[0]}};
  assign c[0] = '0;

  for (genvar i = 1; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_cell
      logic x, y, z;
      assign x = a[j] & b[i];
      if (j == N - 1) begin : g_top
        assign y = 1'b0;
      end else begin : g_mid
        assign y = s[i-1][j+1];
      end
      assign z = c[i-1][j];
      assign s[i][j] = x ^ y ^ z;
      assign c[i][j] = (x & y) | (x & z) | (y & z);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lo
    assign lo[i] = s[i][0];
  end

  assign fa = W'({1'b0, s[N-1][N-1:1]});
  assign fb = W'(c[N-1]);
  assign bc[0] = 1'b0;

  for (genvar k = 0; k < NB; k++) begin : g_blk
    logic [BLK:0] r0, r1;
    assign r0 = {1'b0, fa[k*BLK +: BLK]} + {1'b0, fb[k*BLK +: BLK]};
    assign r1 = {1'b0, fa[k*BLK +: BLK]} + {1'b0, fb[k*BLK +: BLK]} + (BLK+1)'(1);
    assign fs[k*BLK +: BLK] = bc[k] ? r1[BLK-1:0] : r0[BLK-1:0];
    assign bc[k+1]          = bc[k] ? r1[BLK]     : r0[BLK];
  end

  if (W > N) begin : g_pad
    assign merge_ovf = bc[NB] | (|fs[W-1:N]);
  end else begin : g_nopad
    assign merge_ovf = bc[NB];
  end

  assign prod = {fs[N-1:0], lo};

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) p <= '0;
      else        p <= prod;
  end else begin : g_comb
    assign p = prod;
  end
endmodule

// File: rtl/csa_mult_chk.sv
module csa_mult_chk #(
  parameter int N       = 8,
  parameter int REG_OUT = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [2*N-1:0] p,
  input logic           merge_ovf
);
  logic [2*N-1:0] ref_p;
  assign ref_p = {{N{1'b0}}, a} * {{N{1'b0}}, b};

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !merge_ovf);

  if (REG_OUT != 0) begin : g_seq
    assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> p == $past(ref_p));
    assert_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> p[0] == $past(a[0] & b[0]));
    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(a == '0 || b == '0)) |-> p == '0);
    assert_reset_R3: assert property (@(posedge clk)
      !rst_n |-> p == '0);
  end else begin : g_cmb
    assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      p == ref_p);
    assert_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      p[0] == (a[0] & b[0]));
    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (a == '0 || b == '0) |-> p == '0);
  end
endmodule

bind csa_mult csa_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p), .merge_ovf(merge_ovf)
);

// File: tb/csa_mult_bench.sv
`timescale 1ns/1ps
module csa_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  csa_mult #(.N(8), .REG_OUT(1)) u_csa_mult (
    .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .p(p8));
  csa_mult #(.N(4), .REG_OUT(0)) u_csa_mult_n4 (
    .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .p(p4));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply8(string req, logic [7:0] x, logic [7:0] y);
    @(negedge clk);
    a8 = x; b8 = y;
    @(negedge clk);
    check(req, p8, 16'(x) * 16'(y));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    @(negedge clk);
    a8 = 8'hAB; b8 = 8'hCD;
    @(negedge clk);
    check("R3 reset holds zero", p8, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 one-cycle latency", p8, 16'hAB * 16'hCD);
    a8 = 8'h12; b8 = 8'h34;
    #2;
    check("R2 no change before edge", p8, 16'hAB * 16'hCD);
  endtask

  task automatic t_exhaustive4;
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        a4 = 4'(x); b4 = 4'(y);
        #1;
        check("R1 exhaustive N=4 (R2 comb)", 16'(p4), 16'(x * y));
      end
  endtask

  task automatic t_random8;
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] x, y;
      x = 8'($urandom); y = 8'($urandom);
      apply8("R1 random N=8", x, y);
      check("R4 lsb", 16'(p8[0]), 16'(x[0] & y[0]));
    end
  endtask

  task automatic t_zero_one;
    apply8("R6 a zero", 8'h00, 8'h9E);
    apply8("R6 b zero", 8'h7F, 8'h00);
    apply8("R6 both zero", 8'h00, 8'h00);
    apply8("R7 b one", 8'hC3, 8'h01);
    apply8("R7 a one", 8'h01, 8'h5A);
  endtask

  task automatic t_shift;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      a8 = 8'hB7; b8 = 8'(1 << k);
      @(negedge clk);
      check("R8 power-of-two multiplier", p8, 16'(8'hB7) << k);
    end
  endtask

  task automatic t_carry;
    @(negedge clk);
    a8 = 8'hFF; b8 = 8'hFF;
    @(negedge clk);
    check("R5 all ones", p8, 16'hFE01);
    apply8("R5 near max", 8'hFF, 8'hFE);
    apply8("R5 block carry", 8'hF1, 8'hEF);
    apply8("R5 alternating", 8'hAA, 8'h55);
    apply8("R5 high bits", 8'h80, 8'hFF);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_exhaustive4();
    t_zero_one();
    t_shift();
    t_carry();
    t_random8();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule